// File: doc/BRIEF.md
# Down-Counting Timer With Two Compare Points

This block is one timer channel. It counts down from a programmable period value to zero, then reloads that value and keeps counting, so it runs periodically. Each count step is taken on a single-cycle tick strobe. Both strobes are synchronous to the system clock, and a control input picks which of the two strobes drives the counter.

Two compare registers can raise interrupt events partway through a period. Their relative order does not matter, because the counter meets the larger value first and the smaller value second. A third event can occur at the zero crossing. The interrupt output does not pulse. It inverts its level on every event, so a rising edge and a falling edge each mark one event.

Software reads and writes four word registers through a simple write strobe and an address. The enable, clock-select and zero-event enable arrive as direct control inputs.

Top module: `dmt_timer`

## Requirements
- R1: After reset, the count, the period, both compare values and the interrupt level are all zero.
- R2: One cycle after `en_i` rises, the count equals the period register.
- R3: While enabled, each selected tick lowers the count by one. A tick at count zero loads the period value instead.
- R4: With `ext_sel_i` = 0 only `bus_tick_i` advances the count. With `ext_sel_i` = 1 only `ext_tick_i` advances it. The unselected strobe has no effect on the count.
- R5: A tick that brings the count to a nonzero value equal to either compare value inverts `irq_o`. If both compare values are equal, `irq_o` inverts only once.
- R6: A tick that brings the count to zero inverts `irq_o` only if `ovf_irq_en_i` is set or either compare value is zero.
- R7: A write to offset 0x0 while enabled loads the written value into the count, and `irq_o` does not change. A write to offset 0x0 while disabled is ignored.
- R8: While `en_i` is low, the count and `irq_o` hold their values whatever ticks arrive.
- R9: The registers sit at byte offsets 0x0 (count), 0x4 (period), 0x8 (compare A) and 0xC (compare B), and `reg_rdata_o` shows the register selected by `reg_addr_i[3:2]` without a clock delay. A compare write takes effect at once, within the current period.
- R10: `irq_o` changes only in the cycle after an event, and it inverts exactly once per event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Counter enable |
| ext_sel_i | input | 1 | Tick source select: 0 picks the bus tick, 1 picks the external tick |
| ovf_irq_en_i | input | 1 | Enables the event at the zero crossing |
| bus_tick_i | input | 1 | Bus-clock tick strobe |
| ext_tick_i | input | 1 | External-clock tick strobe |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register byte offset |
| reg_wdata_i | input | CW | Register write data |
| reg_rdata_o | output | CW | Register read data |
| irq_o | output | 1 | Interrupt line; its level inverts on each event |

## Verification
The hardest cases to reach are the ones where the event rules overlap. These are two equal compare values, a compare value of zero folding into the zero-crossing rule, and a compare value rewritten after the period has started. The stimulus gets there by stepping the counter one tick at a time with a short period. It rewrites the compare registers at a chosen count, so that each rule is met in isolation and the expected level of `irq_o` is known after every tick.

// File: rtl/dmt_pkg.sv
package dmt_pkg;
  typedef enum logic [1:0] {
    SEL_COUNT  = 2'd0,
    SEL_PERIOD = 2'd1,
    SEL_CMP_A  = 2'd2,
    SEL_CMP_B  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/dmt_tick_sel.sv
module dmt_tick_sel #(
  parameter int NSRC = 2,
  localparam int SW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0] tick_i,
  input  logic [SW-1:0]   sel_i,
  output logic            tick_o
);
  always_comb begin
    tick_o = 1'b0;
    for (int i = 0; i < NSRC; i++)
      if (sel_i == SW'(i)) tick_o = tick_i[i];
  end
endmodule

// File: rtl/dmt_count_core.sv
module dmt_count_core #(
  parameter int CW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          tick_i,
  input  logic          ld_i,
  input  logic [CW-1:0] ld_val_i,
  input  logic [CW-1:0] period_i,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] nxt_o,
  output logic          step_o
);
  logic          en_q;
  logic [CW-1:0] cnt_q;
  logic          start;

  assign start  = en_i & ~en_q;
  assign nxt_o  = (cnt_q == '0) ? period_i : cnt_q - CW'(1);
  assign step_o = en_i & ~ld_i & ~start & tick_i;
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      en_q <= en_i;
      if (en_i) begin
        if (ld_i)       cnt_q <= ld_val_i;
        else if (start) cnt_q <= period_i;
        else if (tick_i) cnt_q <= nxt_o;
      end
    end
  end

  // R2
  start_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start && !ld_i) |=> (cnt_q == $past(period_i)));

  // R3
  step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CW'(1)));

  // R3
  wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o && cnt_q == '0) |=> (cnt_q == $past(period_i)));

  // R8
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(cnt_q));
endmodule

// File: rtl/dmt_match_eval.sv
module dmt_match_eval #(
  parameter int CW = 32
) (
  input  logic          step_i,
  input  logic [CW-1:0] nxt_i,
  input  logic [CW-1:0] cmp_a_i,
  input  logic [CW-1:0] cmp_b_i,
  input  logic          ovf_en_i,
  output logic          evt_o
);
  logic at_zero, hit_cmp, zero_armed;

  assign at_zero    = (nxt_i == '0);
  assign hit_cmp    = (nxt_i == cmp_a_i) | (nxt_i == cmp_b_i);
  assign zero_armed = ovf_en_i | (cmp_a_i == '0) | (cmp_b_i == '0);
  // one event per step even when both compares are equal
  assign evt_o = step_i & (at_zero ? zero_armed : hit_cmp);
endmodule

// File: rtl/dmt_irq_tog.sv
module dmt_irq_tog (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic evt_i,
  output logic irq_o
);
  logic irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    irq_q <= 1'b0;
    else if (evt_i) irq_q <= ~irq_q;
  end

  assign irq_o = irq_q;

  // R10
  evt_flip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i |=> (irq_q != $past(irq_q)));

  // R10
  no_spurious_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q != $past(irq_q)) |-> $past(evt_i));

  // R8
  quiet_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(irq_q));
endmodule

// File: rtl/dmt_timer.sv
module dmt_timer
  import dmt_pkg::*;
#(
  parameter int CW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          ext_sel_i,
  input  logic          ovf_irq_en_i,
  input  logic          bus_tick_i,
  input  logic          ext_tick_i,
  input  logic          reg_we_i,
  input  logic [3:0]    reg_addr_i,
  input  logic [CW-1:0] reg_wdata_i,
  output logic [CW-1:0] reg_rdata_o,
  output logic          irq_o
);
  reg_sel_e      sel;
  logic [CW-1:0] period_q, cmp_a_q, cmp_b_q;
  logic [CW-1:0] cnt, nxt;
  logic          tick, ld, step, evt;

  assign sel = reg_sel_e'(reg_addr_i[3:2]);
  assign ld  = reg_we_i & en_i & (sel == SEL_COUNT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      period_q <= '0;
      cmp_a_q  <= '0;
      cmp_b_q  <= '0;
    end else if (reg_we_i) begin
      case (sel)
        SEL_PERIOD: period_q <= reg_wdata_i;
        SEL_CMP_A:  cmp_a_q  <= reg_wdata_i;
        SEL_CMP_B:  cmp_b_q  <= reg_wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      SEL_COUNT:  reg_rdata_o = cnt;
      SEL_PERIOD: reg_rdata_o = period_q;
      SEL_CMP_A:  reg_rdata_o = cmp_a_q;
      default:    reg_rdata_o = cmp_b_q;
    endcase
  end

  dmt_tick_sel #(.NSRC(2)) u_tick (
    .tick_i ({ext_tick_i, bus_tick_i}),
    .sel_i  (ext_sel_i),
    .tick_o (tick)
  );

  dmt_count_core #(.CW(CW)) u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .tick_i   (tick),
    .ld_i     (ld),
    .ld_val_i (reg_wdata_i),
    .period_i (period_q),
    .cnt_o    (cnt),
    .nxt_o    (nxt),
    .step_o   (step)
  );

  dmt_match_eval #(.CW(CW)) u_match (
    .step_i   (step),
    .nxt_i    (nxt),
    .cmp_a_i  (cmp_a_q),
    .cmp_b_i  (cmp_b_q),
    .ovf_en_i (ovf_irq_en_i),
    .evt_o    (evt)
  );

  dmt_irq_tog u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .evt_i  (evt),
    .irq_o  (irq_o)
  );

  // R7
  load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld |=> (cnt == $past(reg_wdata_i)) && (irq_o == $past(irq_o)));

  // R4
  unsel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !ld && (ext_sel_i ? !ext_tick_i : !bus_tick_i)) |-> !step);
endmodule

// File: tb/sim_dmt_timer.sv
module sim_dmt_timer;
  localparam int CW = 32;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          en = 1'b0, ext_sel = 1'b0, ovf_en = 1'b0;
  logic          bus_tick = 1'b0, ext_tick = 1'b0;
  logic          we = 1'b0;
  logic [3:0]    addr = '0;
  logic [CW-1:0] wdata = '0;
  logic [CW-1:0] rdata;
  logic          irq;

  int total = 0, bad = 0;
  logic exp_irq = 1'b0;
  bit done = 0;

  always #5 clk = ~clk;

  dmt_timer #(.CW(CW)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .ext_sel_i(ext_sel),
    .ovf_irq_en_i(ovf_en), .bus_tick_i(bus_tick), .ext_tick_i(ext_tick),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(input string req, input logic [CW-1:0] act, input logic [CW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [CW-1:0] v);
    we = 1'b0; addr = a; #1; v = rdata;
  endtask

  task automatic wr(input logic [3:0] a, input logic [CW-1:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic tick_bus();
    @(negedge clk); bus_tick = 1'b1;
    @(negedge clk); bus_tick = 1'b0;
  endtask

  task automatic tick_ext();
    @(negedge clk); ext_tick = 1'b1;
    @(negedge clk); ext_tick = 1'b0;
  endtask

  task automatic expect_state(input string req, input logic [CW-1:0] c, input logic i);
    logic [CW-1:0] v;
    rd(4'h0, v);
    check(req, v, c);
    check(req, CW'(irq), CW'(i));
  endtask

  task automatic t_reset();
    logic [CW-1:0] v;
    rd(4'h0, v); check("R1 count", v, 0);
    rd(4'h4, v); check("R1 period", v, 0);
    rd(4'h8, v); check("R1 cmpA", v, 0);
    rd(4'hC, v); check("R1 cmpB", v, 0);
    check("R1 irq", CW'(irq), 0);
  endtask

  task automatic t_regs();
    logic [CW-1:0] v;
    wr(4'h4, 5); wr(4'h8, 3); wr(4'hC, 4);
    rd(4'h4, v); check("R9 period", v, 5);
    rd(4'h8, v); check("R9 cmpA", v, 3);
    rd(4'hC, v); check("R9 cmpB", v, 4);
  endtask

  task automatic t_count_match();
    @(negedge clk); en = 1'b1;
    @(negedge clk);
    expect_state("R2 start", 5, exp_irq);
    tick_bus(); exp_irq = ~exp_irq; expect_state("R5 larger", 4, exp_irq);
    tick_bus(); exp_irq = ~exp_irq; expect_state("R5 smaller", 3, exp_irq);
    tick_bus(); expect_state("R3 dec", 2, exp_irq);
    tick_bus(); expect_state("R3 dec", 1, exp_irq);
    tick_bus(); expect_state("R6 zero silent", 0, exp_irq);
    tick_bus(); expect_state("R3 wrap", 5, exp_irq);
  endtask

  task automatic t_select();
    tick_ext(); expect_state("R4 ext ignored", 5, exp_irq);
    @(negedge clk); ext_sel = 1'b1;
    tick_bus(); expect_state("R4 bus ignored", 5, exp_irq);
    tick_ext(); exp_irq = ~exp_irq; expect_state("R4 ext step", 4, exp_irq);
  endtask

  task automatic t_load_ovf();
    wr(4'h0, 2); expect_state("R7 load", 2, exp_irq);
    @(negedge clk); ovf_en = 1'b1;
    tick_ext(); expect_state("R3 dec", 1, exp_irq);
    tick_ext(); exp_irq = ~exp_irq; expect_state("R6 ovf zero", 0, exp_irq);
  endtask

  task automatic t_disabled();
    @(negedge clk); en = 1'b0;
    wr(4'h0, 7); expect_state("R7 ignored off", 0, exp_irq);
    tick_ext(); expect_state("R8 hold", 0, exp_irq);
    tick_ext(); expect_state("R8 hold", 0, exp_irq);
  endtask

  task automatic t_zero_cmp();
    @(negedge clk); ovf_en = 1'b0;
    wr(4'h4, 3); wr(4'h8, 2); wr(4'hC, 0);
    @(negedge clk); en = 1'b1;
    @(negedge clk);
    expect_state("R2 restart", 3, exp_irq);
    tick_ext(); exp_irq = ~exp_irq; expect_state("R5 cmpA", 2, exp_irq);
    tick_ext(); expect_state("R3 dec", 1, exp_irq);
    tick_ext(); exp_irq = ~exp_irq; expect_state("R6 cmp zero", 0, exp_irq);
  endtask

  task automatic t_equal_and_update();
    wr(4'hC, 2);
    tick_ext(); expect_state("R3 wrap", 3, exp_irq);
    tick_ext(); exp_irq = ~exp_irq; expect_state("R5 equal once", 2, exp_irq);
    tick_ext(); expect_state("R3 dec", 1, exp_irq);
    tick_ext(); expect_state("R6 zero silent", 0, exp_irq);
    tick_ext(); expect_state("R3 wrap", 3, exp_irq);
    wr(4'h8, 1);
    tick_ext(); exp_irq = ~exp_irq; expect_state("R5 cmpB", 2, exp_irq);
    tick_ext(); exp_irq = ~exp_irq; expect_state("R9 new cmp", 1, exp_irq);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_count_match();
    t_select();
    t_load_ovf();
    t_disabled();
    t_zero_cmp();
    t_equal_and_update();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule